// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between several processor request ports and one shared word-addressed memory. It provides plain loads and stores together with an atomic pair of operations. A load-linked returns a word and opens a reservation for the requesting port on that address. A later store-conditional from the same port writes the word only if no other port has written that address in the meantime. It then reports pass or fail. Software builds locks, counters and other read-modify-write sequences from this pair. No bus lock is needed.

A fixed-priority arbiter grants one request per cycle. Port 0 has the highest priority. Every write that reaches memory is compared against all the reservations the other ports hold. A matching reservation is dropped. A failed store-conditional never touches memory, so it disturbs no other port. Each port keeps a single reservation. The response comes back on the registered outputs one cycle after the grant.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, no response is valid, every memory word reads zero and no port holds a reservation, so a store-conditional issued before any load-linked fails.
- R2: Operation codes are 0 load, 1 store, 2 load-linked and 3 store-conditional. Among the ports whose request is valid, the lowest-indexed one is granted: its `req_ready` bit is high and no other bit is high. A port that is not granted keeps its request pending.
- R3: In the cycle after a grant, `rsp_valid` is high for the granted port only. For a load or load-linked, `rsp_rdata` carries the word as it was before that cycle's write. For a store or store-conditional it carries zero. A store always writes its data.
- R4: A store-conditional from a port whose reservation is valid and matches the full word address writes the data and returns `rsp_sc_ok` = 1.
- R5: A failing store-conditional returns `rsp_sc_ok` = 0, leaves memory unchanged and clears no other port's reservation.
- R6: A store by another port to the reserved address, including a store of zero used to release a lock, makes the holder's next store-conditional there fail.
- R7: A write by another port to a different address leaves the reservation intact.
- R8: Every store-conditional, whether it passes or fails, clears the issuing port's reservation, so a second store-conditional without a new load-linked fails.
- R9: A new load-linked replaces the port's earlier reservation, and the new address is the one that is matched.
- R10: When two ports issue store-conditionals to the same reserved address in the same cycle, the higher-priority one passes and the other then fails.
- R11: A store-conditional to an address other than the port's reserved one fails.
- R12: A port's own store to its reserved address does not cancel its reservation.
- R13: A passing store-conditional cancels the matching reservations of all other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_op | input | 2*NPORTS | Operation code per port, port i at bits 2i+1:2i |
| req_addr | input | AW*NPORTS | Word address per port |
| req_wdata | input | DW*NPORTS | Write data per port |
| req_ready | output | NPORTS | Grant, one-hot or zero |
| rsp_valid | output | NPORTS | Response valid for the port granted a cycle earlier |
| rsp_rdata | output | DW | Read data of the response |
| rsp_sc_ok | output | 1 | Store-conditional passed |

## Verification
The bench targets these corners:
- Two store-conditionals racing in one cycle. A design that checked both against stale reservations would let both pass and lose one update.
- A store-conditional repeated without a new load-linked. A design that kept the reservation after use would pass it twice.
- A store of zero that releases a lock. If writes were not snooped against every other port, the released waiters would pass wrongly.
- A port's own store, and a write to a neighbouring address. A design that cleared reservations too broadly would fail store-conditionals that should pass.
- A failing store-conditional. A design that let its data through would change memory that a later load exposes.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LD = 2'd0,
    OP_ST = 2'd1,
    OP_LL = 2'd2,
    OP_SC = 2'd3
  } op_e;

  // true when the granted operation reaches memory
  function automatic logic is_write(input op_e op, input logic pass);
    return (op == OP_ST) || ((op == OP_SC) && pass);
  endfunction

  // true when the response carries the memory word
  function automatic logic returns_data(input op_e op);
    return (op == OP_LD) || (op == OP_LL);
  endfunction

endpackage

// File: rtl/llsc_arb.sv
module llsc_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);
  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        gidx   = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) arr[k] <= '0;
    end else if (we) begin
      arr[addr] <= wdata;
    end
  end

  assign rdata = arr[addr];
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
  import llsc_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  gnt,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  output logic          sc_pass,
  output logic [N-1:0]  kill
);
  logic [N-1:0]  held;
  logic [AW-1:0] where [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign kill[i] = wr_en && !gnt[i] && held[i] && (where[i] == addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[i]  <= 1'b0;
        where[i] <= '0;
      end else if (gnt[i] && op == OP_LL) begin
        held[i]  <= 1'b1;
        where[i] <= addr;
      end else if ((gnt[i] && op == OP_SC) || kill[i]) begin
        held[i]  <= 1'b0;
      end
    end
  end

  always_comb begin
    sc_pass = 1'b0;
    for (int i = 0; i < N; i++)
      if (gnt[i] && held[i] && where[i] == addr) sc_pass = 1'b1;
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [2*NPORTS-1:0]  req_op,
  input  logic [AW*NPORTS-1:0] req_addr,
  input  logic [DW*NPORTS-1:0] req_wdata,
  output logic [NPORTS-1:0]    req_ready,
  output logic [NPORTS-1:0]    rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_sc_ok
);
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [NPORTS-1:0] grant_oh;
  logic [IW-1:0]     grant_idx;
  logic              grant_any;
  op_e               sel_op;
  logic [AW-1:0]     sel_addr;
  logic [DW-1:0]     sel_wdata;
  logic              sc_pass;
  logic              sc_fail;
  logic              wr_en;
  logic [NPORTS-1:0] snoop_kill;
  logic [DW-1:0]     mem_rdata;

  llsc_arb #(.N(NPORTS), .IW(IW)) u_arb (
    .req (req_valid),
    .gnt (grant_oh),
    .gidx(grant_idx),
    .any (grant_any)
  );

  assign req_ready = grant_oh;

  always_comb begin
    sel_op    = OP_LD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (grant_oh[i]) begin
        sel_op    = op_e'(req_op[2*i +: 2]);
        sel_addr  = req_addr[AW*i +: AW];
        sel_wdata = req_wdata[DW*i +: DW];
      end
    end
  end

  llsc_resv #(.N(NPORTS), .AW(AW)) u_resv (
    .clk    (clk),
    .rst_n  (rst_n),
    .gnt    (grant_oh),
    .op     (sel_op),
    .addr   (sel_addr),
    .wr_en  (wr_en),
    .sc_pass(sc_pass),
    .kill   (snoop_kill)
  );

  assign wr_en   = grant_any && is_write(sel_op, sc_pass);
  assign sc_fail = grant_any && (sel_op == OP_SC) && !sc_pass;

  llsc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .addr (sel_addr),
    .wdata(sel_wdata),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= grant_oh;
      rsp_rdata <= (grant_any && returns_data(sel_op)) ? mem_rdata : '0;
      rsp_sc_ok <= grant_any && (sel_op == OP_SC) && sc_pass;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] req_valid,
  input logic [NPORTS-1:0] req_ready,
  input logic [NPORTS-1:0] rsp_valid,
  input logic              rsp_sc_ok,
  input logic              wr_en,
  input logic              sc_fail,
  input logic [NPORTS-1:0] snoop_kill
);
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  a_r3_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (rsp_valid == $past(req_ready)));

  a_r4_pass_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_sc_ok |-> $onehot(rsp_valid));

  a_r5_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fail |-> !wr_en);

  a_r6_kill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|snoop_kill) |-> wr_en);
endmodule

bind llsc_monitor llsc_monitor_chk #(.NPORTS(NPORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_sc_ok (rsp_sc_ok),
  .wr_en     (wr_en),
  .sc_fail   (sc_fail),
  .snoop_kill(snoop_kill)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/100ps
module test_llsc_monitor;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int LD = 0, ST = 1, LL = 2, SC = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     req_valid;
  logic [2*NP-1:0]   req_op;
  logic [AW*NP-1:0]  req_addr;
  logic [DW*NP-1:0]  req_wdata;
  logic [NP-1:0]     req_ready;
  logic [NP-1:0]     rsp_valid;
  logic [DW-1:0]     rsp_rdata;
  logic              rsp_sc_ok;

  always #2.5 clk = ~clk;

  llsc_monitor #(.NPORTS(NP), .DW(DW), .AW(AW)) i_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok));

  // pending requests per port
  bit          pv [NP];
  int          pop [NP];
  logic [AW-1:0] pa [NP];
  logic [DW-1:0] pd [NP];

  // behavioural reference state
  logic [DW-1:0] m [256];
  bit            rv [NP];
  logic [AW-1:0] ra [NP];

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic rq(input int p, input int op, input int a, input logic [DW-1:0] d);
    pv[p] = 1'b1; pop[p] = op; pa[p] = AW'(a); pd[p] = d;
  endtask

  task automatic model_write(input int g, input logic [AW-1:0] a, input logic [DW-1:0] d);
    m[a] = d;
    for (int j = 0; j < NP; j++)
      if (j != g && rv[j] && ra[j] == a) rv[j] = 1'b0;
  endtask

  // one clock: drive, check grant, model the edge, check response
  task automatic step(input string tag);
    int g;
    logic [NP-1:0] eg, ev;
    logic [DW-1:0] er;
    logic eok;
    for (int p = 0; p < NP; p++) begin
      req_valid[p]           = pv[p];
      req_op[2*p +: 2]       = 2'(pop[p]);
      req_addr[AW*p +: AW]   = pa[p];
      req_wdata[DW*p +: DW]  = pd[p];
    end
    #1;
    g = -1;
    for (int p = NP-1; p >= 0; p--) if (pv[p]) g = p;
    eg = '0;
    if (g >= 0) eg[g] = 1'b1;
    chk(tag, "req_ready", DW'(req_ready), DW'(eg));
    @(posedge clk);
    ev = eg; er = '0; eok = 1'b0;
    if (g >= 0) begin
      case (pop[g])
        LD: er = m[pa[g]];
        LL: begin er = m[pa[g]]; rv[g] = 1'b1; ra[g] = pa[g]; end
        ST: model_write(g, pa[g], pd[g]);
        default: begin
          if (rv[g] && ra[g] == pa[g]) begin
            model_write(g, pa[g], pd[g]);
            eok = 1'b1;
          end
          rv[g] = 1'b0;
        end
      endcase
      pv[g] = 1'b0;
    end
    @(negedge clk);
    chk(tag, "rsp_valid", DW'(rsp_valid), DW'(ev));
    chk(tag, "rsp_rdata", rsp_rdata, er);
    chk(tag, "rsp_sc_ok", DW'(rsp_sc_ok), DW'(eok));
  endtask

  task automatic drain(input string tag);
    while (pv[0] || pv[1] || pv[2] || pv[3]) step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int p = 0; p < NP; p++) begin pv[p] = 0; pop[p] = 0; pa[p] = '0; pd[p] = '0; rv[p] = 0; ra[p] = '0; end
    for (int k = 0; k < 256; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs after reset, then SC with no reservation, then zero memory
    chk("R1", "rsp_valid idle", DW'(rsp_valid), '0);
    step("R1");
    rq(0, SC, 5, 32'h55); step("R1");
    rq(1, LD, 5, 0); step("R1");
    // R3: store then load from another port
    rq(0, ST, 10, 32'hA); step("R3");
    rq(1, LD, 10, 0); step("R3");
    // R2: three ports at once, priority order
    rq(3, LD, 10, 0); rq(1, LD, 10, 0); rq(2, ST, 11, 32'h11);
    step("R2"); step("R2"); step("R2");
    // R4 / R8 / R5
    rq(0, LL, 10, 0); step("R4");
    rq(0, SC, 10, 32'hB); step("R4");
    rq(0, SC, 10, 32'hC); step("R8");
    rq(2, LD, 10, 0); step("R5");
    // R6: intervening store by another port
    rq(1, LL, 20, 0); step("R6");
    rq(2, ST, 20, 32'h20); step("R6");
    rq(1, SC, 20, 32'hDEAD); step("R6");
    rq(1, LD, 20, 0); step("R5");
    // R7: neighbouring address
    rq(1, LL, 30, 0); step("R7");
    rq(2, ST, 31, 32'h31); step("R7");
    rq(1, SC, 30, 32'h30); step("R7");
    // R9 / R11
    rq(2, LL, 40, 0); step("R9");
    rq(2, LL, 41, 0); step("R9");
    rq(2, SC, 41, 32'h41); step("R9");
    rq(2, LL, 40, 0); step("R11");
    rq(2, SC, 41, 32'h99); step("R11");
    // R12: own store keeps reservation
    rq(3, LL, 50, 0); step("R12");
    rq(3, ST, 50, 32'h7); step("R12");
    rq(3, SC, 50, 32'h8); step("R12");
    // R10 / R13: racing SCs
    rq(1, LL, 60, 0); rq(2, LL, 60, 0); drain("R10");
    rq(1, SC, 60, 32'h61); rq(2, SC, 60, 32'h62); step("R10"); step("R13");
    rq(3, LD, 60, 0); step("R13");
    // R6: unlock store of zero releases waiters
    rq(0, LL, 70, 0); rq(3, LL, 70, 0); drain("R6");
    rq(1, ST, 70, 32'h0); step("R6");
    rq(0, SC, 70, 32'h1); rq(3, SC, 70, 32'h1); drain("R6");
    // mixed traffic on a few shared words
    for (int c = 0; c < 400; c++) begin
      for (int p = 0; p < NP; p++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        if (!pv[p] && seed[31]) rq(p, int'(seed[9:8]), int'(seed[5:4]) + 80, {seed[27:12], seed[15:0]});
      end
      step("R13");
    end
    drain("R2");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule